// File: doc/BRIEF.md
# Peripheral Alert Service Poller

This block sits on the host side of a multi-drop serial link. It watches the service-request alerts of up to `NUM_PERIPH` peripherals and picks the one to service next. An alert is active low: a peripheral pulls it low while it wants attention. The `shared_mode` input selects the wiring and is held static during operation.

In dedicated wiring (`shared_mode` = 0), each peripheral has its own alert pin. The requester is known at once and is granted without any status poll. In shared wiring (`shared_mode` = 1), all alerts are merged onto one wired-OR line. A low level on that line only says that someone is waiting. The block then issues status polls to the peripherals in rotation and grants each one that answers "needs service". It keeps doing this until the line goes high.

Each grant is passed to a downstream transaction engine and is held there until that engine signals completion. One rotating pointer records the last peripheral polled or granted. Both modes share this pointer, so no peripheral is starved.

Top module: `alert_svc_poller`

## Requirements
- R1: After synchronous reset, `poll_req` and `grant_valid` are low, and the rotation pointer is at index `NUM_PERIPH-1`, so the first candidate is index 0.
- R2: In dedicated mode, a low `alert_n_ded[i]` leads to a grant with `grant_idx` = i, and `poll_req` is never raised.
- R3: In dedicated mode with several alerts low, grants go in ascending circular order, starting at the index just after the last granted or polled one.
- R4: `grant_valid` and `grant_idx` stay stable until `grant_done` is sampled high, and `grant_valid` and `poll_req` are never high together.
- R5: In shared mode, while the synchronized shared line is low, polls are issued to the index just after the last polled or granted index, wrapping from `NUM_PERIPH-1` to 0.
- R6: `poll_req` stays high with a stable `poll_idx` until `poll_ack` is sampled high. Only one poll is outstanding at any time.
- R7: A `poll_ack` with `poll_needs_svc` = 1 raises `grant_valid` on the next cycle for the polled index. With `poll_needs_svc` = 0, no grant is made for that index and the pointer moves past it.
- R8: Polling and granting stop when no alert is low. In shared mode the dedicated inputs are ignored, and in dedicated mode the shared input is ignored.
- R9: Alerts pass through a two-flop synchronizer. From idle, a dedicated alert that goes low before a rising edge gives `grant_valid` high right after the third rising edge.
- R10: After `grant_done` is sampled, the block waits for the synchronizer depth before it looks at the alerts again. With another dedicated alert already pending, the next grant appears after the fourth rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shared_mode | input | 1 | 1 selects shared wired-OR wiring, 0 selects dedicated pins |
| alert_n_ded | input | NUM_PERIPH | Dedicated active-low alerts, bit i for peripheral i |
| alert_n_shr | input | 1 | Shared active-low wired-OR alert |
| poll_req | output | 1 | Status poll request |
| poll_idx | output | IDX_W | Index of the peripheral being polled |
| poll_ack | input | 1 | Poll response is valid |
| poll_needs_svc | input | 1 | Poll response: the peripheral needs service |
| grant_valid | output | 1 | Grant is pending toward the transaction engine |
| grant_idx | output | IDX_W | Index of the granted peripheral |
| grant_done | input | 1 | The transaction engine has finished the grant |

## Verification
The bench targets these corner cases:

- **Pointer carry-over.** The rotation pointer carries over between runs and between modes. A design that restarted from index 0, or kept separate pointers, would grant or poll in the wrong order in later vectors.
- **Shared line held low.** Shared runs leave the line low while another peripheral still waits, and include polls that answer "no". A design that stopped after one grant, or granted a non-requester, would miss a peripheral or produce an extra grant.
- **Released alert during sync delay.** The release of an alert at `grant_done` tests the settle window. Without that window the block would grant the same peripheral again from stale synchronizer contents.
- **Ignored input per mode.** Toggling the input that the current mode must ignore checks that no poll or grant leaks out.

// File: rtl/alert_svc_pkg.sv
package alert_svc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_POLL   = 2'd1,
        ST_GRANT  = 2'd2,
        ST_SETTLE = 2'd3
    } svc_state_e;

    typedef struct packed {
        svc_state_e state;
        logic       shared;
    } svc_ctx_t;

    // Width of an index into n peripherals, at least one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/alert_sync.sv
module alert_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_n,
    output logic [WIDTH-1:0] sync_n
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= '1;
                end else if (s == 0) begin
                    stage_q[s] <= async_n;
                end else begin
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             any,
    output logic [IDX_W-1:0] pick
);
    always_comb begin
        int c;
        logic [IDX_W-1:0] cand;
        any  = 1'b0;
        pick = '0;
        // Walk from farthest to nearest so the nearest requester wins.
        for (int k = N; k >= 1; k--) begin
            c = int'(last) + k;
            if (c >= N) c = c - N;
            cand = IDX_W'(c);
            if (req[cand]) begin
                any  = 1'b1;
                pick = cand;
            end
        end
    end

endmodule

// File: rtl/alert_svc_poller.sv
module alert_svc_poller
    import alert_svc_pkg::*;
#(
    parameter int NUM_PERIPH  = 4,
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = idx_width(NUM_PERIPH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shared_mode,
    input  logic [NUM_PERIPH-1:0] alert_n_ded,
    input  logic                  alert_n_shr,
    output logic                  poll_req,
    output logic [IDX_W-1:0]      poll_idx,
    input  logic                  poll_ack,
    input  logic                  poll_needs_svc,
    output logic                  grant_valid,
    output logic [IDX_W-1:0]      grant_idx,
    input  logic                  grant_done
);
    localparam int SYNC_W = NUM_PERIPH + 1;
    localparam int CNT_W  = $clog2(SYNC_STAGES + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PERIPH - 1);
    localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SYNC_STAGES - 1);

    logic [SYNC_W-1:0]     sync_n;
    logic [NUM_PERIPH-1:0] ded_req;
    logic                  shr_req;
    logic                  pick_any;
    logic [IDX_W-1:0]      pick_idx;

    svc_ctx_t              ctx_q, ctx_d;
    logic [IDX_W-1:0]      last_q, last_d;
    logic [IDX_W-1:0]      cur_q, cur_d;
    logic [CNT_W-1:0]      cnt_q, cnt_d;

    alert_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n ({alert_n_shr, alert_n_ded}),
        .sync_n  (sync_n)
    );

    assign ded_req = ~sync_n[NUM_PERIPH-1:0];
    assign shr_req = ~sync_n[NUM_PERIPH];

    rr_picker #(.N(NUM_PERIPH), .IDX_W(IDX_W)) u_pick (
        .req  (ded_req),
        .last (last_q),
        .any  (pick_any),
        .pick (pick_idx)
    );

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] v);
        return (v == LAST_IDX) ? '0 : v + 1'b1;
    endfunction

    always_comb begin
        ctx_d        = ctx_q;
        ctx_d.shared = shared_mode;
        last_d       = last_q;
        cur_d        = cur_q;
        cnt_d        = cnt_q;
        unique case (ctx_q.state)
            ST_IDLE: begin
                if (shared_mode) begin
                    if (shr_req) begin
                        ctx_d.state = ST_POLL;
                        cur_d       = next_idx(last_q);
                    end
                end else if (pick_any) begin
                    ctx_d.state = ST_GRANT;
                    cur_d       = pick_idx;
                end
            end
            ST_POLL: begin
                if (poll_ack) begin
                    if (poll_needs_svc) begin
                        ctx_d.state = ST_GRANT;
                    end else begin
                        ctx_d.state = ST_IDLE;
                        last_d      = cur_q;
                    end
                end
            end
            ST_GRANT: begin
                if (grant_done) begin
                    ctx_d.state = ST_SETTLE;
                    last_d      = cur_q;
                    cnt_d       = '0;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == SETTLE_END) begin
                    ctx_d.state = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: ctx_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q  <= '{state: ST_IDLE, shared: 1'b0};
            last_q <= LAST_IDX;
            cur_q  <= '0;
            cnt_q  <= '0;
        end else begin
            ctx_q  <= ctx_d;
            last_q <= last_d;
            cur_q  <= cur_d;
            cnt_q  <= cnt_d;
        end
    end

    assign poll_req    = (ctx_q.state == ST_POLL);
    assign poll_idx    = cur_q;
    assign grant_valid = (ctx_q.state == ST_GRANT);
    assign grant_idx   = cur_q;

    AST_EXCLUSIVE_OUT: assert property (@(posedge clk) disable iff (rst)
        !(poll_req && grant_valid)); // R4

    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !grant_done) |=> (grant_valid && $stable(grant_idx))); // R4

    AST_POLL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (poll_req && !poll_ack) |=> (poll_req && $stable(poll_idx))); // R6

    AST_NO_POLL_DED: assert property (@(posedge clk) disable iff (rst)
        (!shared_mode && !ctx_q.shared) |-> !poll_req); // R2

    AST_ACK_GRANT: assert property (@(posedge clk) disable iff (rst)
        (poll_req && poll_ack && poll_needs_svc) |=>
            (grant_valid && grant_idx == $past(poll_idx))); // R7

    AST_ACK_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (poll_req && poll_ack && !poll_needs_svc) |=> (!grant_valid && !poll_req)); // R7

    AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && grant_done) |=> (!grant_valid && !poll_req)); // R10

endmodule

// File: tb/alert_svc_poller_test.sv
module alert_svc_poller_test;

    localparam int N = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          shared_mode;
    logic [N-1:0]  alert_n_ded;
    logic          alert_n_shr;
    logic          poll_req;
    logic [IW-1:0] poll_idx;
    logic          poll_ack;
    logic          poll_needs_svc;
    logic          grant_valid;
    logic [IW-1:0] grant_idx;
    logic          grant_done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int model_ptr;

    always #10 clk = ~clk;

    alert_svc_poller #(.NUM_PERIPH(N), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .shared_mode(shared_mode),
        .alert_n_ded(alert_n_ded), .alert_n_shr(alert_n_shr),
        .poll_req(poll_req), .poll_idx(poll_idx),
        .poll_ack(poll_ack), .poll_needs_svc(poll_needs_svc),
        .grant_valid(grant_valid), .grant_idx(grant_idx),
        .grant_done(grant_done)
    );

    // Vector: [18] shared, [17:14] pending, [13:11] grant count,
    // [10:3] grant order (entry k at [3+2k +: 2]), [2:0] poll count.
    localparam logic [18:0] VEC [8] = '{
        {1'b0, 4'b0101, 3'd2, {2'd0, 2'd0, 2'd2, 2'd0}, 3'd0},
        {1'b0, 4'b1011, 3'd3, {2'd0, 2'd1, 2'd0, 2'd3}, 3'd0},
        {1'b0, 4'b0100, 3'd1, {2'd0, 2'd0, 2'd0, 2'd2}, 3'd0},
        {1'b1, 4'b1001, 3'd2, {2'd0, 2'd0, 2'd0, 2'd3}, 3'd2},
        {1'b1, 4'b0100, 3'd1, {2'd0, 2'd0, 2'd0, 2'd2}, 3'd2},
        {1'b1, 4'b1111, 3'd4, {2'd2, 2'd1, 2'd0, 2'd3}, 3'd4},
        {1'b0, 4'b1000, 3'd1, {2'd0, 2'd0, 2'd0, 2'd3}, 3'd0},
        {1'b0, 4'b1111, 3'd4, {2'd3, 2'd2, 2'd1, 2'd0}, 3'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        shared_mode = 1'b0;
        alert_n_ded = '1;
        alert_n_shr = 1'b1;
        poll_ack = 1'b0;
        poll_needs_svc = 1'b0;
        grant_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_ptr = N - 1;
    endtask

    task automatic quiet(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (poll_req || grant_valid) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic run_vec(input logic [18:0] v);
        logic [N-1:0] pend;
        bit shr;
        int got = 0, polls = 0, pcyc = 0, gstep = 0, gap = 0, t = 0;
        bit gap_on = 0;
        logic [IW-1:0] gi = '0;
        shr  = v[18];
        pend = v[17:14];
        shared_mode = shr;
        alert_n_ded = shr ? '1 : ~pend;
        alert_n_shr = shr ? (pend == '0) : 1'b1;
        while ((pend != '0 || gstep != 0) && t < 2000) begin
            @(negedge clk);
            t++;
            poll_ack = 1'b0;
            if (!grant_valid && gap_on) gap++;
            if (poll_req) begin
                pcyc++;
                if (pcyc == 2) begin
                    check(int'(poll_idx) == (model_ptr + 1) % N, "R5 poll order",
                          poll_idx, (model_ptr + 1) % N);
                    model_ptr = poll_idx;
                    poll_ack = 1'b1;
                    poll_needs_svc = pend[poll_idx];
                    polls++;
                end
            end else begin
                pcyc = 0;
            end
            if (gstep == 2) begin
                grant_done = 1'b0;
                gstep = 0;
            end else if (grant_valid && gstep == 0) begin
                gi = grant_idx;
                if (got < 4)
                    check(grant_idx == v[3 + 2*got +: 2], shr ? "R7 shared grant" : "R3 grant order",
                          grant_idx, v[3 + 2*got +: 2]);
                if (!shr && gap_on)
                    check(gap == 3, "R10 settle gap", gap, 3);
                gap_on = 0;
                got++;
                gstep = 1;
            end else if (grant_valid && gstep == 1) begin
                check(grant_idx == gi, "R4 grant hold", grant_idx, gi);
                pend[gi] = 1'b0;
                model_ptr = gi;
                alert_n_ded = shr ? '1 : ~pend;
                alert_n_shr = shr ? (pend == '0) : 1'b1;
                grant_done = 1'b1;
                gstep = 2;
                gap = 0;
                gap_on = 1;
            end
        end
        check(got == int'(v[13:11]), "R2 grant count", got, v[13:11]);
        check(polls == int'(v[2:0]), "R5 poll count", polls, v[2:0]);
        quiet(12, "R8 idle after service");
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        check(poll_req == 1'b0, "R1 poll_req reset", poll_req, 0);
        check(grant_valid == 1'b0, "R1 grant_valid reset", grant_valid, 0);

        // R9: latency through the synchronizer; R1: first candidate index
        alert_n_ded = 4'b1101;
        @(negedge clk);
        check(grant_valid == 1'b0, "R9 after edge 1", grant_valid, 0);
        @(negedge clk);
        check(grant_valid == 1'b0, "R9 after edge 2", grant_valid, 0);
        @(negedge clk);
        check(grant_valid == 1'b1, "R9 after edge 3", grant_valid, 1);
        check(grant_idx == 2'd1, "R2 grant index", grant_idx, 1);
        alert_n_ded = '1;
        grant_done = 1'b1;
        @(negedge clk);
        grant_done = 1'b0;
        quiet(8, "R8 no regrant");

        // R8: inputs of the other mode are ignored
        shared_mode = 1'b1;
        alert_n_ded = '0;
        quiet(20, "R8 dedicated ignored in shared mode");
        alert_n_ded = '1;
        quiet(4, "R8 settle");
        shared_mode = 1'b0;
        alert_n_shr = 1'b0;
        quiet(20, "R8 shared ignored in dedicated mode");
        alert_n_shr = 1'b1;
        quiet(4, "R8 settle");

        // Reset check of the first candidate, then the vector table
        do_reset();
        for (int i = 0; i < 8; i++) run_vec(VEC[i]);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule